// File: doc/BRIEF.md
# Dual-Channel Reloading Down-Counter Timer

This block holds two independent down-counters with their own reload values, reached by a host over a byte-wide register bus. When a counter is enabled, each pulse of the timebase tick input lowers it by one. When it steps from one to zero it raises a sticky flag. On the next enabled tick it takes its reload value back instead of wrapping. Each flag, gated by its own interrupt enable, gives one interrupt request output.

A shared control register groups the two count enables, the two interrupt enables, the two flags and a two-bit output-mode field. The output-mode field drives a single timer output pin from channel 1. That pin can follow channel 1's zero events by toggling, or it can be held low or high. When the mode is 00 the timer leaves the pin alone, and an external select input must also be high before the timer drives the pin. A flag is cleared by reading the control register and then reading a byte of that channel's counter. Reading a counter's low byte captures its high byte, so a 16-bit value read as two bytes stays coherent.

Top module: `dual_reload_timer`

## Requirements
- R1: After reset the control register at address 0x10 reads 0x00. Both counters and both reload registers read 0xFFFF. irq0, irq1 and tout_en are 0 and tout is 1.
- R2: Control register layout: bit 7 is the channel 1 flag, bit 6 the channel 0 flag, bit 5 the channel 1 interrupt enable, bit 4 the channel 0 interrupt enable, bits 3:2 the output mode and bit 1 / bit 0 the channel 1 / channel 0 count enables. A write updates bits 5:0 only. Bits 7:6 ignore writes.
- R3: A tick with the channel enabled, when the counter holds 1, moves the counter to 0 and sets the flag in the same clock edge.
- R4: A read of either counter byte of a channel clears its flag only if the control register was read after that channel's last counter read. A counter read without that earlier control read leaves the flag set.
- R5: A tick with the channel enabled, when the counter holds 0, loads the reload value and does not set the flag.
- R6: With the channel's count enable at 0, ticks leave the counter and the flag unchanged.
- R7: irqN is 1 exactly while channel N's flag and interrupt enable are both 1.
- R8: Output mode 01 toggles tout on each channel 1 step to zero. Mode 10 drives tout low and mode 11 drives it high one clock after the mode is written. Mode 00 holds tout and keeps tout_en low.
- R9: tout_en is 1 only while out_sel is 1 and the output mode is not 00.
- R10: A read of a counter's low byte captures its high byte. A high-byte read returns that captured byte, even if the counter has changed since.
- R11: The counter bytes (channel 0 at 0x0C/0x0D, channel 1 at 0x14/0x15) and the reload bytes (0x0E/0x0F, 0x16/0x17, low byte first) can be written. A written value is read back and used by the next ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Register address |
| rd | input | 1 | Read strobe; side effects occur at the clock edge |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| tick | input | 1 | Timebase pulse, one clock wide |
| out_sel | input | 1 | Enables the timer to drive its output pin |
| irq0 | output | 1 | Channel 0 interrupt request |
| irq1 | output | 1 | Channel 1 interrupt request |
| tout | output | 1 | Timer output level |
| tout_en | output | 1 | Timer output drive enable |

## Verification
Channel 0 is run through a short count of 2 with a reload of 3. This separates the step to zero (flag set) from the reload step (no flag) and from the decrements after the reload. The clear sequence is tried both with and without the control read beforehand, so a design that clears the flag on any counter read is caught. Channel 1 runs with a reload of 1, so toggles on every second tick can be told apart from toggles on every tick. The output modes are then changed with no ticks in between, which shows that forcing low or high does not depend on the counter. Changing the high byte between the low and high reads shows whether the captured byte is returned or the live one.

// File: rtl/timer_pkg.sv
package timer_pkg;

   typedef enum logic [1:0] {
      TO_OFF    = 2'b00,
      TO_TOGGLE = 2'b01,
      TO_LOW    = 2'b10,
      TO_HIGH   = 2'b11
   } tout_mode_e;

   localparam int unsigned NUM_CH = 2;

endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
   parameter int unsigned  CNT_W  = 16,
   parameter int unsigned  ADDR_W = 8,
   parameter logic [7:0]   BASE   = 8'h0C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cnt_en,
   input  logic              rd,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              ctrl_rd,
   output logic [7:0]        rdata_o,
   output logic              hit_o,
   output logic              flag_o,
   output logic              zero_evt_o
);

   localparam logic [ADDR_W-1:0] A_CL = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] A_CH = ADDR_W'(BASE + 8'd1);
   localparam logic [ADDR_W-1:0] A_RL = ADDR_W'(BASE + 8'd2);
   localparam logic [ADDR_W-1:0] A_RH = ADDR_W'(BASE + 8'd3);
   localparam logic [CNT_W-1:0]  ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt, reload;
   logic [15:0]      cnt_ext, rld_ext;
   logic [7:0]       hi_latch;
   logic             armed;
   logic             sel_cl, sel_ch, sel_rl, sel_rh;
   logic             cnt_wr, cnt_rd, step, clr_req;

   assign sel_cl  = (addr == A_CL);
   assign sel_ch  = (addr == A_CH);
   assign sel_rl  = (addr == A_RL);
   assign sel_rh  = (addr == A_RH);
   assign hit_o   = sel_cl | sel_ch | sel_rl | sel_rh;
   assign cnt_wr  = wr & (sel_cl | sel_ch);
   assign cnt_rd  = rd & (sel_cl | sel_ch);
   assign step    = tick & cnt_en & ~cnt_wr;
   assign zero_evt_o = step & (cnt == ONE);
   assign clr_req = cnt_rd & armed;
   assign cnt_ext = 16'(cnt);
   assign rld_ext = 16'(reload);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '1;
      end else if (wr && sel_cl) begin
         cnt <= CNT_W'({cnt_ext[15:8], wdata});
      end else if (wr && sel_ch) begin
         cnt <= CNT_W'({wdata, cnt_ext[7:0]});
      end else if (step) begin
         cnt <= (cnt == '0) ? reload : cnt - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload <= '1;
      end else if (wr && sel_rl) begin
         reload <= CNT_W'({rld_ext[15:8], wdata});
      end else if (wr && sel_rh) begin
         reload <= CNT_W'({wdata, rld_ext[7:0]});
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_o   <= 1'b0;
         armed    <= 1'b0;
         hi_latch <= '0;
      end else begin
         if (zero_evt_o)   flag_o <= 1'b1;
         else if (clr_req) flag_o <= 1'b0;
         if (ctrl_rd)      armed  <= 1'b1;
         else if (cnt_rd)  armed  <= 1'b0;
         if (rd && sel_cl) hi_latch <= cnt_ext[15:8];
      end
   end

   always_comb begin
      unique case (1'b1)
         sel_cl:  rdata_o = cnt_ext[7:0];
         sel_ch:  rdata_o = hi_latch;
         sel_rl:  rdata_o = rld_ext[7:0];
         sel_rh:  rdata_o = rld_ext[15:8];
         default: rdata_o = 8'h00;
      endcase
   end

   AST_FLAG_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_en && !cnt_wr && cnt == ONE) |=> (flag_o && cnt == '0)); // R3
   AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !zero_evt_o) |=> !flag_o); // R4
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cnt_en && !cnt_wr && cnt == '0) |=> (cnt == $past(reload))); // R5
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick && cnt_en) && !cnt_wr) |=> $stable(cnt)); // R6

endmodule

// File: rtl/tmr_outpin.sv
module tmr_outpin
   import timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  tout_mode_e mode,
   input  logic       zero_evt,
   input  logic       out_sel,
   output logic       tout,
   output logic       tout_en
);

   logic tout_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tout_q <= 1'b1;
      end else begin
         unique case (mode)
            TO_LOW:    tout_q <= 1'b0;
            TO_HIGH:   tout_q <= 1'b1;
            TO_TOGGLE: if (zero_evt) tout_q <= ~tout_q;
            default:   tout_q <= tout_q;
         endcase
      end
   end

   assign tout    = tout_q;
   assign tout_en = out_sel & (mode != TO_OFF);

   AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TO_LOW) |=> !tout_q); // R8
   AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TO_HIGH) |=> tout_q); // R8
   AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TO_TOGGLE && zero_evt) |=> (tout_q != $past(tout_q))); // R8
   AST_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == TO_OFF) |=> $stable(tout_q)); // R8

endmodule

// File: rtl/dual_reload_timer.sv
module dual_reload_timer
   import timer_pkg::*;
#(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter logic [7:0]  CTRL_ADDR = 8'h10,
   parameter logic [7:0]  CH0_BASE  = 8'h0C,
   parameter logic [7:0]  CH1_BASE  = 8'h14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              tick,
   input  logic              out_sel,
   output logic              irq0,
   output logic              irq1,
   output logic              tout,
   output logic              tout_en
);

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);

   if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
      $error("CNT_W must lie in 9..16");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end
   if (CTRL_ADDR >= CH0_BASE && CTRL_ADDR < CH0_BASE + 8'd4) begin : g_bad_map0
      $error("control address overlaps channel 0");
   end
   if (CTRL_ADDR >= CH1_BASE && CTRL_ADDR < CH1_BASE + 8'd4) begin : g_bad_map1
      $error("control address overlaps channel 1");
   end

   logic [NUM_CH-1:0] ie, en, flag, hit, zero_evt;
   logic [7:0]        ch_rdata [NUM_CH];
   tout_mode_e        mode;
   logic              ctrl_hit, ctrl_rd;

   assign ctrl_hit = (addr == A_CTRL);
   assign ctrl_rd  = rd & ctrl_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie   <= '0;
         en   <= '0;
         mode <= TO_OFF;
      end else if (wr && ctrl_hit) begin
         ie   <= wdata[5:4];
         mode <= tout_mode_e'(wdata[3:2]);
         en   <= wdata[1:0];
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      tmr_channel #(
         .CNT_W  (CNT_W),
         .ADDR_W (ADDR_W),
         .BASE   ((g == 0) ? CH0_BASE : CH1_BASE)
      ) u_ch (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick       (tick),
         .cnt_en     (en[g]),
         .rd         (rd),
         .wr         (wr),
         .addr       (addr),
         .wdata      (wdata),
         .ctrl_rd    (ctrl_rd),
         .rdata_o    (ch_rdata[g]),
         .hit_o      (hit[g]),
         .flag_o     (flag[g]),
         .zero_evt_o (zero_evt[g])
      );
   end

   always_comb begin
      if (ctrl_hit)    rdata = {flag[1], flag[0], ie[1], ie[0], mode, en[1], en[0]};
      else if (hit[0]) rdata = ch_rdata[0];
      else if (hit[1]) rdata = ch_rdata[1];
      else             rdata = 8'h00;
   end

   assign irq0 = flag[0] & ie[0];
   assign irq1 = flag[1] & ie[1];

   tmr_outpin u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .zero_evt (zero_evt[1]),
      .out_sel  (out_sel),
      .tout     (tout),
      .tout_en  (tout_en)
   );

   AST_CTRL_RO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && ctrl_hit && zero_evt == '0) |=> (flag == $past(flag) || flag < $past(flag))); // R2

endmodule

// File: tb/dual_reload_timer_test.sv
module dual_reload_timer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr = '0;
   logic       rd = 1'b0, wr = 1'b0, tick = 1'b0, out_sel = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       irq0, irq1, tout, tout_en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dual_reload_timer uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr),
      .wdata(wdata), .rdata(rdata), .tick(tick), .out_sel(out_sel),
      .irq0(irq0), .irq1(irq1), .tout(tout), .tout_en(tout_en)
   );

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [7:0] a, logic [7:0] d);
      @(negedge clk); addr = a; wdata = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic bus_rd(logic [7:0] a, output logic [7:0] d);
      @(negedge clk); addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
      end
   endtask

   task automatic idle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      bus_rd(8'h10, d); check("R1 ctrl", d, 8'h00);
      bus_rd(8'h0E, d); check("R1 reload0 lo", d, 8'hFF);
      bus_rd(8'h17, d); check("R1 reload1 hi", d, 8'hFF);
      bus_rd(8'h14, d); check("R1 cnt1 lo", d, 8'hFF);
      bus_rd(8'h15, d); check("R1 cnt1 hi", d, 8'hFF);
      check("R1 outputs", {irq0, irq1, tout_en, tout}, 4'b0001);
   endtask

   task automatic t_ctrl();
      logic [7:0] d;
      bus_wr(8'h10, 8'hFF);
      bus_rd(8'h10, d); check("R2 flags read-only", d, 8'h3F);
      bus_wr(8'h10, 8'h00);
      bus_rd(8'h10, d); check("R2 clear", d, 8'h00);
   endtask

   task automatic t_ch0();
      logic [7:0] d;
      bus_wr(8'h0E, 8'h03); bus_wr(8'h0F, 8'h00);
      bus_wr(8'h0C, 8'h02); bus_wr(8'h0D, 8'h00);
      bus_wr(8'h10, 8'h01);
      ticks(1);
      bus_rd(8'h0C, d); check("R11 cnt0 lo after write+tick", d, 8'h01);
      bus_rd(8'h0D, d); check("R11 cnt0 hi", d, 8'h00);
      ticks(1);
      check("R7 irq0 masked", irq0, 1'b0);
      bus_rd(8'h10, d); check("R3 flag0 set", d, 8'h41);
      bus_wr(8'h10, 8'h11);
      check("R7 irq0 raised", irq0, 1'b1);
      ticks(1);
      bus_rd(8'h0C, d); check("R5 reload value", d, 8'h03);
      bus_rd(8'h10, d); check("R4 flag0 cleared after sequence", d, 8'h11);
      check("R7 irq0 dropped", irq0, 1'b0);
      bus_rd(8'h0C, d);
      ticks(3);
      bus_rd(8'h0C, d); check("R3 cnt0 at zero", d, 8'h00);
      check("R4 counter read without ctrl read keeps flag", irq0, 1'b1);
      bus_rd(8'h10, d); check("R4 flag still set", d, 8'h51);
      bus_rd(8'h0D, d);
      check("R4 hi-byte read clears flag", irq0, 1'b0);
      bus_wr(8'h10, 8'h10);
      ticks(3);
      bus_rd(8'h0C, d); check("R6 frozen counter", d, 8'h00);
      check("R6 no flag when frozen", irq0, 1'b0);
   endtask

   task automatic t_latch();
      logic [7:0] d;
      bus_wr(8'h14, 8'h34); bus_wr(8'h15, 8'h12);
      bus_rd(8'h14, d); check("R10 lo", d, 8'h34);
      bus_wr(8'h15, 8'h56);
      bus_rd(8'h15, d); check("R10 captured hi", d, 8'h12);
      bus_rd(8'h14, d);
      bus_rd(8'h15, d); check("R10 new hi", d, 8'h56);
   endtask

   task automatic t_tout();
      logic [7:0] d;
      out_sel = 1'b1;
      bus_wr(8'h16, 8'h01); bus_wr(8'h17, 8'h00);
      bus_wr(8'h14, 8'h01); bus_wr(8'h15, 8'h00);
      bus_wr(8'h10, 8'h26);
      check("R9 tout_en on", tout_en, 1'b1);
      ticks(1);
      check("R8 toggle 1", tout, 1'b0);
      check("R7 irq1", irq1, 1'b1);
      bus_rd(8'h10, d); check("R2 flag1 bit7", d, 8'hA6);
      ticks(1);
      check("R8 no toggle on reload", tout, 1'b0);
      ticks(1);
      check("R8 toggle 2", tout, 1'b1);
      bus_wr(8'h10, 8'h2A); idle();
      check("R8 force low", tout, 1'b0);
      bus_wr(8'h10, 8'h2E); idle();
      check("R8 force high", tout, 1'b1);
      bus_wr(8'h10, 8'h22); idle();
      check("R8 mode 00 tout_en", tout_en, 1'b0);
      ticks(2);
      check("R8 mode 00 holds pin", tout, 1'b1);
      bus_wr(8'h10, 8'h26);
      out_sel = 1'b0;
      idle();
      check("R9 select low", tout_en, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      t_reset();
      t_ctrl();
      t_ch0();
      t_latch();
      t_tout();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule